// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side master for a low-power successive-approximation converter that returns each sample as a 16-bit serial word. It makes the converter's select line and serial clock from the system clock. The half-period of the serial clock is set by a run-time divider. The select line first goes low for a programmable power-up and acquisition window. It then goes high, which starts the conversion, and exactly sixteen serial clock periods follow. The data line is sampled, the four leading zeros are removed, and the 12-bit result is handed on through a valid/ready output.

A `start` pulse asks for one conversion. A pulse that arrives while a frame or the spacing interval is still running is remembered until it can be served. While `continuous` is high, conversions repeat as fast as the programmed sample period allows. All timing settings are counted in system clock cycles, and each is captured when the select line falls.

Top module: `adc_frame_reader`

## Requirements
- R1: At a launch, `cs_n` goes low and stays low for exactly max(`wake_cycles`,1) system cycles, then goes high.
- R2: After `cs_n` rises, `sclk` stays high for H = max(`half_div`,1) cycles. It then makes exactly 16 periods, each phase lasting H cycles, and the frame ends on the 16th rising edge.
- R3: Between frames, and while `cs_n` is low, `sclk` is held high and `cs_n` is held high (outside the power-up window).
- R4: Two `cs_n` falling edges are at least max(`period_cycles`,1) cycles apart, using the value captured at the earlier launch. A frame must end before the next launch, which comes one cycle after the frame ends at the earliest.
- R5: Bit 0 of the frame is sampled in the cycle before the first `sclk` fall. Bits 1 to 15 are sampled as `sclk` rises after falls 1 to 15. The bits arrive most significant first, and `res_data` is the last 12 of them.
- R6: `zero_err` is set and stays set if any of the first four frame bits is 1. The result is still delivered.
- R7: `res_valid` rises in the cycle after the frame ends and stays high until `res_ready` is seen high. A result that arrives while `res_valid` is high and `res_ready` is low replaces the held one and sets the sticky `overflow` flag.
- R8: A `start` pulse is remembered until the launch that serves it. While `continuous` is high, a new frame launches at the first cycle R4 permits. Outside the sampling instants, the data line has no effect on the result.
- R9: After reset, `cs_n`=1, `sclk`=1, `res_valid`=0, `zero_err`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion |
| continuous | input | 1 | Repeat conversions at the programmed period |
| half_div | input | DIV_W | Serial clock half-period in system cycles (0 is treated as 1) |
| wake_cycles | input | CNT_W | Length of the select-low power-up window (0 is treated as 1) |
| period_cycles | input | CNT_W | Minimum spacing of select falling edges (0 is treated as 1) |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| res_data | output | DATA_W | Latest 12-bit result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| zero_err | output | 1 | Sticky: a leading bit was sampled as 1 |
| overflow | output | 1 | Sticky: an unread result was replaced |

## Verification
On every cycle, the assertions check the following: `sclk` stays high whenever the select line is low, the select falls only while `sclk` is high, and select falls are spaced by the captured period. They also check that `res_valid` is held while unread, that a replaced result raises `overflow`, and that both flags are sticky. Only the bench scenarios can show the exact length of each phase, the sampling instants, and the bit order. The same holds for the leading-zero check against a driven frame and for the remembered start pulse, because these need a converter model that answers the serial clock. The bench's reference model predicts `cs_n`, `sclk`, and the result outputs for every cycle across several divider, window and period settings.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 12,
  parameter int FRAME  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              continuous,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [CNT_W-1:0]  wake_cycles,
  input  logic [CNT_W-1:0]  period_cycles,
  output logic              cs_n,
  output logic              sclk,
  input  logic              sdata,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              zero_err,
  output logic              overflow
);
  localparam int EW = $clog2(FRAME + 1);
  localparam logic [EW-1:0] LAST = EW'(FRAME);

  typedef enum logic [1:0] {IDLE, WAKE, XFER} st_t;
  st_t st;

  logic [DIV_W-1:0] div_q, hcnt, div_eff;
  logic [CNT_W-1:0] wcnt, gap, per_q, wake_eff, per_eff;
  logic [EW-1:0]    falls;
  logic [FRAME-1:0] sh;
  logic             pend, launch, edge_now, done;

  assign div_eff  = (half_div == '0)      ? DIV_W'(1) : half_div;
  assign wake_eff = (wake_cycles == '0)   ? CNT_W'(1) : wake_cycles;
  assign per_eff  = (period_cycles == '0) ? CNT_W'(1) : period_cycles;

  assign launch   = (st == IDLE) && (gap == '0) && (pend || start || continuous);
  assign edge_now = (st == XFER) && (hcnt == '0);
  assign done     = edge_now && !sclk && (falls == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cs_n  <= 1'b1;
      sclk  <= 1'b1;
      div_q <= DIV_W'(1);
      hcnt  <= '0;
      wcnt  <= '0;
      gap   <= '0;
      per_q <= CNT_W'(1);
      falls <= '0;
      sh    <= '0;
      pend  <= 1'b0;
    end else begin
      pend <= (pend | start) & ~launch;
      if (launch)          gap <= per_eff - 1'b1;
      else if (gap != '0)  gap <= gap - 1'b1;
      case (st)
        IDLE: if (launch) begin
          st    <= WAKE;
          cs_n  <= 1'b0;
          wcnt  <= wake_eff - 1'b1;
          div_q <= div_eff;
          per_q <= per_eff;
        end
        WAKE: begin
          if (wcnt == '0) begin
            st    <= XFER;
            cs_n  <= 1'b1;
            hcnt  <= div_q - 1'b1;
            falls <= '0;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        XFER: begin
          if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
          end else begin
            hcnt <= div_q - 1'b1;
            if (sclk) begin
              sclk  <= 1'b0;
              falls <= falls + 1'b1;
              if (falls == '0) sh <= {sh[FRAME-2:0], sdata};
            end else begin
              sclk <= 1'b1;
              if (falls != LAST) sh <= {sh[FRAME-2:0], sdata};
              else               st <= IDLE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_valid <= 1'b0;
      zero_err  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      res_valid <= done | (res_valid & ~res_ready);
      if (done) begin
        res_data <= sh[DATA_W-1:0];
        if (|sh[FRAME-1:DATA_W])         zero_err <= 1'b1;
        if (res_valid && !res_ready)     overflow <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             res_valid,
  input logic             res_ready,
  input logic             overflow,
  input logic             zero_err,
  input logic             done,
  input logic [CNT_W-1:0] per_q
);
  logic [31:0] since_fall;
  logic        cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_fall <= '0;
      cs_d       <= 1'b1;
    end else begin
      cs_d <= cs_n;
      if (!cs_n && cs_d)             since_fall <= 32'd1;
      else if (since_fall != '0 && since_fall != 32'hFFFF_FFFF)
                                     since_fall <= since_fall + 32'd1;
    end
  end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> sclk);
  // R1
  cs_fall_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk);
  // R2
  cs_rise_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> sclk);
  // R4
  fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && since_fall != '0) |-> (since_fall >= 32'($past(per_q))));
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);
  // R7
  overwrite_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_valid && !res_ready) |=> overflow);
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R6
  zero_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |=> zero_err);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .res_valid(res_valid), .res_ready(res_ready), .overflow(overflow),
  .zero_err(zero_err), .done(done), .per_q(per_q)
);

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, continuous = 1'b0, res_ready = 1'b1;
  logic [7:0]  half_div = 8'd1;
  logic [15:0] wake_cycles = 16'd3, period_cycles = 16'd5;
  logic        cs_n, sclk, res_valid, zero_err, overflow;
  logic        sdata = 1'b1;
  logic [11:0] res_data;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  adc_frame_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
    .half_div(half_div), .wake_cycles(wake_cycles), .period_cycles(period_cycles),
    .cs_n(cs_n), .sclk(sclk), .sdata(sdata), .res_data(res_data),
    .res_valid(res_valid), .res_ready(res_ready), .zero_err(zero_err),
    .overflow(overflow)
  );

  // converter model: bit 0 on select rise, next bit on each sclk fall
  logic [15:0] next_word = 16'h0000, conv_word = 16'h0000;
  int bitn = 0;
  always @(negedge cs_n) conv_word = next_word;
  always @(posedge cs_n) begin bitn = 0; sdata = conv_word[15]; end
  always @(negedge sclk) if (cs_n) begin
    bitn++;
    sdata = (bitn < 16) ? conv_word[15 - bitn] : 1'b1;
  end

  // cycle reference model
  int m_t, m_P, m_H, m_T, m_since;
  bit m_active, m_pend, m_valid, m_err, m_ovf, m_done, m_launch;
  bit exp_cs, exp_sclk;
  logic [11:0] m_data;

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_pend = 0; m_valid = 0; m_err = 0; m_ovf = 0;
      m_since = 1000000; m_T = 1; m_t = 0; m_P = 1; m_H = 1; m_data = '0;
      exp_cs = 1; exp_sclk = 1;
    end else begin
      m_done = 0; m_launch = 0;
      if (m_since < 1000000) m_since++;
      if (m_active) begin
        m_t++;
        if (m_t == m_P + 32 * m_H) begin m_active = 0; m_done = 1; end
      end else if (m_since >= m_T && (m_pend || start || continuous)) begin
        m_launch = 1; m_active = 1; m_t = 0; m_since = 0;
        m_P = eff(wake_cycles); m_H = eff(half_div); m_T = eff(period_cycles);
      end
      m_pend = (m_pend || start) && !m_launch;
      if (m_done) begin
        if (m_valid && !res_ready) m_ovf = 1;
        m_valid = 1;
        m_data = conv_word[11:0];
        if (conv_word[15:12] != 4'h0) m_err = 1;
      end else if (m_valid && res_ready) m_valid = 0;
      if (m_active) begin
        exp_cs = (m_t >= m_P);
        if (m_t < m_P + m_H) exp_sclk = 1;
        else exp_sclk = (((m_t - m_P - m_H) / m_H) % 2) != 0;
      end else begin
        exp_cs = 1; exp_sclk = 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check("R9 cs_n reset", int'(cs_n), 1);
      check("R9 sclk reset", int'(sclk), 1);
      check("R9 res_valid reset", int'(res_valid), 0);
      check("R9 flags reset", int'({zero_err, overflow}), 0);
    end else begin
      check("R1 R4 R8 cs_n", int'(cs_n), int'(exp_cs));
      check("R2 R3 sclk", int'(sclk), int'(exp_sclk));
      check("R7 res_valid", int'(res_valid), int'(m_valid));
      if (m_valid) check("R5 R8 res_data", int'(res_data), int'(m_data));
      check("R6 zero_err", int'(zero_err), int'(m_err));
      check("R7 overflow", int'(overflow), int'(m_ovf));
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    // R1 R2 R5: shortest divider, mixed word
    next_word = 16'h0ABC;
    pulse_start();
    idle(60);
    // R5 all ones, then R8 start remembered during a frame
    @(negedge clk) begin half_div = 8'd3; wake_cycles = 16'd10; period_cycles = 16'd300; end
    next_word = 16'h0FFF;
    pulse_start();
    idle(6);
    next_word = 16'h0000;
    idle(30);
    pulse_start();
    idle(700);
    // R7 overflow with ready low, continuous frames
    @(negedge clk) begin half_div = 8'd1; wake_cycles = 16'd1; period_cycles = 16'd40;
      res_ready = 1'b0; continuous = 1'b1; end
    next_word = 16'h0555;
    idle(130);
    @(negedge clk) continuous = 1'b0;
    idle(60);
    @(negedge clk) res_ready = 1'b1;
    idle(20);
    // R6 leading one
    next_word = 16'h8123;
    pulse_start();
    idle(60);
    // zero settings treated as one
    @(negedge clk) begin half_div = 8'd0; wake_cycles = 16'd0; period_cycles = 16'd0; end
    next_word = 16'h0F0F;
    pulse_start();
    idle(60);
    // R4 R8 back-to-back continuous with slower divider
    @(negedge clk) begin half_div = 8'd2; wake_cycles = 16'd4; continuous = 1'b1; end
    next_word = 16'h0A5A;
    idle(300);
    @(negedge clk) continuous = 1'b0;
    idle(120);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule